// File: doc/BRIEF.md
# Telephony Serial Clock Generator

This block produces the timing signals for a voice codec serial highway from one reference clock, nominally 32.768 MHz. A bit clock, an independent control-port (SPI) clock and an 8 kHz frame sync are all derived from one shared 12-bit frame counter. A single-cycle bit-slot strobe marks the first reference cycle of each data bit. The highway runs either in PCM mode, where the bit-clock rate is chosen by a code, or in GCI mode, where the bit clock is fixed at one of two rates. Each mode has its own choice of one or two bit clocks per data bit.

The setting inputs may change at any time and have no effect on their own. A reinitialise strobe captures them. The captured set goes live on the first reference cycle of the next frame. At that point every divider sits at phase zero, so all outputs switch together and no period is cut short.

Top module: `highway_clkgen`

## Requirements
- R1: While `rst` is high, all four outputs are low. The live settings return to PCM mode, rate code 3 for both clocks, and one clock per bit in both modes. The first cycle after reset shows all four outputs high, as the start of a frame.
- R2: In PCM mode a bit-clock rate code c of 0..5 gives a `pclk_o` period of 128>>c reference cycles (256 kHz up to 8.192 MHz), high for the first half. Codes 6 and 7 behave as code 5.
- R3: `sclk_o` uses the same code encoding from `spi_rate_i`, independently of the highway mode and of the bit-clock rate.
- R4: In GCI mode `pclk_o` has a period of 16 reference cycles (2.048 MHz) with one clock per bit, or 8 (4.096 MHz) with two clocks per bit, whatever the PCM rate code.
- R5: `fsync_o` rises every 4096 reference cycles, on the same cycle as a `pclk_o` rising edge, and stays high for exactly one `pclk_o` period.
- R6: `bit_slot_o` is a one-cycle pulse on the rising edge of `pclk_o`. It occurs on every rising edge with one clock per bit, and on every second rising edge (counted from the frame start) with two clocks per bit.
- R7: A change on the setting inputs without a reinitialise strobe leaves all outputs unchanged.
- R8: A strobe captures the settings present in its cycle, and they go live at the next frame start. Setting changes after the strobe are ignored. When several strobes occur within one frame, the last one wins.
- R9: Across any reconfiguration, no high pulse of `pclk_o` or `sclk_o` is shorter than 2 reference cycles, and the frame-sync spacing stays at 4096 cycles.
- R10: A strobe in the last cycle of a frame takes effect at the frame start that immediately follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| gci_mode_i | input | 1 | Highway mode setting: 0 PCM, 1 GCI |
| pcm_rate_i | input | 3 | PCM bit-clock rate code |
| spi_rate_i | input | 3 | SPI clock rate code |
| pcm_dbl_i | input | 1 | PCM: 1 selects two bit clocks per data bit |
| gci_dbl_i | input | 1 | GCI: 1 selects two bit clocks per data bit (4.096 MHz) |
| reinit_i | input | 1 | Reinitialise strobe that captures the setting inputs |
| pclk_o | output | 1 | Highway bit clock |
| sclk_o | output | 1 | SPI clock |
| fsync_o | output | 1 | 8 kHz frame sync |
| bit_slot_o | output | 1 | One-cycle strobe at the start of each data bit |

## Verification
Every output is registered, so each value appears one reference cycle after the counter state it decodes. The reference model therefore computes each cycle's expected value from its own state before the clock edge, and the bench compares it 2 ns after that edge. A reinitialise strobe shows on the outputs only at the frame start that follows, which can be up to 4096 cycles later, or one cycle later when the strobe lands in the frame's last cycle. The named period checks wait for a rising `fsync_o` and then count the high run of `pclk_o`, rather than sampling at a fixed delay after the strobe.

// File: rtl/hwy_pkg.sv
package hwy_pkg;

  localparam int CODE_W = 3;

  typedef struct packed {
    logic              gci;
    logic [CODE_W-1:0] pcm_rate;
    logic [CODE_W-1:0] spi_rate;
    logic              pcm_dbl;
    logic              gci_dbl;
  } hwy_cfg_t;

  localparam hwy_cfg_t CFG_RESET = '{gci: 1'b0, pcm_rate: 3'd3, spi_rate: 3'd3,
                                     pcm_dbl: 1'b0, gci_dbl: 1'b0};

  typedef enum logic [1:0] {
    TAP_LEVEL  = 2'd0,
    TAP_WINDOW = 2'd1,
    TAP_STROBE = 2'd2
  } tap_kind_t;

  // Map a rate code to log2 of the divide, clamping codes above the fastest.
  function automatic int rate_log(input logic [CODE_W-1:0] code,
                                  input int max_log, input int num_codes);
    int c;
    c = (int'(code) >= num_codes) ? num_codes - 1 : int'(code);
    return max_log - c;
  endfunction

endpackage

// File: rtl/hwy_frame_ctr.sv
module hwy_frame_ctr #(
  parameter int FRAME_LOG = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [FRAME_LOG-1:0] cnt_o,
  output logic                 frame_end_o
);

  logic [FRAME_LOG-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + FRAME_LOG'(1);
  end

  assign cnt_o       = cnt_q;
  assign frame_end_o = &cnt_q;

endmodule

// File: rtl/hwy_cfg_stage.sv
module hwy_cfg_stage
  import hwy_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reinit_i,
  input  hwy_cfg_t cfg_i,
  input  logic     frame_end_i,
  output hwy_cfg_t act_o
);

  hwy_cfg_t stg_q;
  hwy_cfg_t act_q;
  logic     pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= CFG_RESET;
      act_q  <= CFG_RESET;
      pend_q <= 1'b0;
    end else if (frame_end_i) begin
      // Swap at the frame boundary, where every divider is at phase zero.
      if (reinit_i)    act_q <= cfg_i;
      else if (pend_q) act_q <= stg_q;
      pend_q <= 1'b0;
    end else if (reinit_i) begin
      stg_q  <= cfg_i;
      pend_q <= 1'b1;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/hwy_phase_tap.sv
module hwy_phase_tap
  import hwy_pkg::*;
#(
  parameter int        CW   = 12,
  parameter int        KW   = 4,
  parameter tap_kind_t KIND = TAP_LEVEL
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [KW-1:0] log_i,
  output logic          val_o
);

  logic [CW-1:0] mask;
  logic [CW-1:0] half_bit;

  always_comb begin
    mask     = (CW'(1) << log_i) - CW'(1);
    half_bit = CW'(1) << (log_i - KW'(1));
  end

  generate
    if (KIND == TAP_LEVEL) begin : g_level
      assign val_o = (cnt_i & half_bit) == '0;
    end else if (KIND == TAP_WINDOW) begin : g_window
      assign val_o = (cnt_i >> log_i) == '0;
    end else begin : g_strobe
      assign val_o = (cnt_i & mask) == '0;
    end
  endgenerate

endmodule

// File: rtl/highway_clkgen.sv
module highway_clkgen
  import hwy_pkg::*;
#(
  parameter int FRAME_LOG = 12,
  parameter int MAX_LOG   = 7,
  parameter int NUM_CODES = 6,
  parameter int GCI1_LOG  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gci_mode_i,
  input  logic [2:0] pcm_rate_i,
  input  logic [2:0] spi_rate_i,
  input  logic       pcm_dbl_i,
  input  logic       gci_dbl_i,
  input  logic       reinit_i,
  output logic       pclk_o,
  output logic       sclk_o,
  output logic       fsync_o,
  output logic       bit_slot_o
);

  localparam int KW = $clog2(FRAME_LOG + 1);
  localparam int NT = 4;

  function automatic tap_kind_t kind_of(input int idx);
    if (idx < 2)  return TAP_LEVEL;
    if (idx == 2) return TAP_WINDOW;
    return TAP_STROBE;
  endfunction

  hwy_cfg_t             cfg_in;
  hwy_cfg_t             act;
  logic [FRAME_LOG-1:0] cnt;
  logic                 frame_end;
  logic [KW-1:0]        pclk_log;
  logic [KW-1:0]        sclk_log;
  logic [KW-1:0]        slot_log;
  logic                 dbl;
  logic [KW-1:0]        tlog [NT];
  logic [NT-1:0]        tap_v;
  logic [NT-1:0]        out_q;

  assign cfg_in = '{gci: gci_mode_i, pcm_rate: pcm_rate_i, spi_rate: spi_rate_i,
                    pcm_dbl: pcm_dbl_i, gci_dbl: gci_dbl_i};

  hwy_frame_ctr #(.FRAME_LOG(FRAME_LOG)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .cnt_o       (cnt),
    .frame_end_o (frame_end)
  );

  hwy_cfg_stage u_cfg (
    .clk         (clk),
    .rst         (rst),
    .reinit_i    (reinit_i),
    .cfg_i       (cfg_in),
    .frame_end_i (frame_end),
    .act_o       (act)
  );

  always_comb begin
    dbl      = act.gci ? act.gci_dbl : act.pcm_dbl;
    if (act.gci)
      pclk_log = act.gci_dbl ? KW'(GCI1_LOG - 1) : KW'(GCI1_LOG);
    else
      pclk_log = KW'(rate_log(act.pcm_rate, MAX_LOG, NUM_CODES));
    sclk_log = KW'(rate_log(act.spi_rate, MAX_LOG, NUM_CODES));
    slot_log = pclk_log + KW'(dbl);
  end

  assign tlog[0] = pclk_log;
  assign tlog[1] = sclk_log;
  assign tlog[2] = pclk_log;
  assign tlog[3] = slot_log;

  generate
    for (genvar g = 0; g < NT; g++) begin : g_tap
      hwy_phase_tap #(.CW(FRAME_LOG), .KW(KW), .KIND(kind_of(g))) u_tap (
        .cnt_i (cnt),
        .log_i (tlog[g]),
        .val_o (tap_v[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= tap_v;
  end

  assign pclk_o     = out_q[0];
  assign sclk_o     = out_q[1];
  assign fsync_o    = out_q[2];
  assign bit_slot_o = out_q[3];

endmodule

// File: rtl/hwy_clkgen_chk.sv
module hwy_clkgen_chk #(
  parameter int FRAME_LOG = 12,
  parameter int MAX_LOG   = 7,
  parameter int NUM_CODES = 6
) (
  input logic clk,
  input logic rst,
  input logic pclk_o,
  input logic sclk_o,
  input logic fsync_o,
  input logic bit_slot_o
);

  localparam int FRAME    = 1 << FRAME_LOG;
  localparam int MIN_HALF = 1 << (MAX_LOG - NUM_CODES);

  logic                 pclk_q, sclk_q, fs_q, seen_q;
  logic [FRAME_LOG:0]   gap_q;
  logic [FRAME_LOG:0]   prun_q, srun_q;
  logic                 fs_rise;

  assign fs_rise = fsync_o & ~fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_q <= 1'b0; sclk_q <= 1'b0; fs_q <= 1'b0; seen_q <= 1'b0;
      gap_q  <= '0;   prun_q <= '0;   srun_q <= '0;
    end else begin
      pclk_q <= pclk_o;
      sclk_q <= sclk_o;
      fs_q   <= fsync_o;
      if (fs_rise) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
      prun_q <= pclk_o ? prun_q + 1'b1 : '0;
      srun_q <= sclk_o ? srun_q + 1'b1 : '0;
    end
  end

  // R5
  fsync_on_pclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> $rose(pclk_o));

  // R5
  frame_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (fs_rise && seen_q) |-> (int'(gap_q) == FRAME - 1));

  // R6
  slot_on_pclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    bit_slot_o |-> $rose(pclk_o));

  // R6
  slot_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    bit_slot_o |=> !bit_slot_o);

  // R9
  pclk_min_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!pclk_o && pclk_q) |-> (int'(prun_q) >= MIN_HALF));

  // R9
  sclk_min_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!sclk_o && sclk_q) |-> (int'(srun_q) >= MIN_HALF));

endmodule

bind highway_clkgen hwy_clkgen_chk #(
  .FRAME_LOG (FRAME_LOG),
  .MAX_LOG   (MAX_LOG),
  .NUM_CODES (NUM_CODES)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .pclk_o     (pclk_o),
  .sclk_o     (sclk_o),
  .fsync_o    (fsync_o),
  .bit_slot_o (bit_slot_o)
);

// File: tb/highway_clkgen_tb_top.sv
`timescale 1ns/1ps
module highway_clkgen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gci_mode_i = 1'b0;
  logic [2:0] pcm_rate_i = 3'd3;
  logic [2:0] spi_rate_i = 3'd3;
  logic       pcm_dbl_i = 1'b0;
  logic       gci_dbl_i = 1'b0;
  logic       reinit_i = 1'b0;
  logic       pclk_o, sclk_o, fsync_o, bit_slot_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  highway_clkgen dut_i (
    .clk(clk), .rst(rst), .gci_mode_i(gci_mode_i), .pcm_rate_i(pcm_rate_i),
    .spi_rate_i(spi_rate_i), .pcm_dbl_i(pcm_dbl_i), .gci_dbl_i(gci_dbl_i),
    .reinit_i(reinit_i), .pclk_o(pclk_o), .sclk_o(sclk_o), .fsync_o(fsync_o),
    .bit_slot_o(bit_slot_o)
  );

  // Behavioural reference model state
  int m_cnt = 0;
  int a_gci = 0, a_pr = 3, a_sr = 3, a_pd = 0, a_gd = 0;
  int s_gci = 0, s_pr = 3, s_sr = 3, s_pd = 0, s_gd = 0;
  bit m_pend = 0;

  function automatic int period_of(input int code);
    int c;
    c = (code > 5) ? 5 : code;
    return 128 / (1 << c);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    int pp, sp, slp;
    int e_p, e_s, e_f, e_b;
    string preq;
    @(posedge clk);
    if (rst) begin
      e_p = 0; e_s = 0; e_f = 0; e_b = 0;
      m_cnt = 0; m_pend = 0;
      a_gci = 0; a_pr = 3; a_sr = 3; a_pd = 0; a_gd = 0;
      preq = "R1";
    end else begin
      pp  = a_gci ? (a_gd ? 8 : 16) : period_of(a_pr);
      sp  = period_of(a_sr);
      slp = pp * (((a_gci && a_gd) || (!a_gci && a_pd)) ? 2 : 1);
      e_p = ((m_cnt % pp) < pp / 2) ? 1 : 0;
      e_s = ((m_cnt % sp) < sp / 2) ? 1 : 0;
      e_f = (m_cnt < pp) ? 1 : 0;
      e_b = ((m_cnt % slp) == 0) ? 1 : 0;
      preq = a_gci ? "R4" : "R2";
      if (m_cnt == 4095) begin
        m_cnt = 0;
        if (reinit_i) begin
          a_gci = gci_mode_i; a_pr = pcm_rate_i; a_sr = spi_rate_i;
          a_pd = pcm_dbl_i; a_gd = gci_dbl_i;
        end else if (m_pend) begin
          a_gci = s_gci; a_pr = s_pr; a_sr = s_sr; a_pd = s_pd; a_gd = s_gd;
        end
        m_pend = 0;
      end else begin
        m_cnt++;
        if (reinit_i) begin
          s_gci = gci_mode_i; s_pr = pcm_rate_i; s_sr = spi_rate_i;
          s_pd = pcm_dbl_i; s_gd = gci_dbl_i;
          m_pend = 1;
        end
      end
    end
    #2;
    check(preq, pclk_o, e_p);
    check("R3", sclk_o, e_s);
    check("R5", fsync_o, e_f);
    check("R6", bit_slot_o, e_b);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic strobe();
    reinit_i = 1'b1;
    step();
    reinit_i = 1'b0;
  endtask

  task automatic set_cfg(input int g, input int pr, input int sr, input int pd, input int gd);
    gci_mode_i = g[0]; pcm_rate_i = pr[2:0]; spi_rate_i = sr[2:0];
    pcm_dbl_i = pd[0]; gci_dbl_i = gd[0];
  endtask

  // Wait for the next fsync rise, return the length of that pclk high run.
  task automatic measure_high(output int len);
    bit prev;
    prev = fsync_o;
    step();
    while (!(fsync_o && !prev)) begin
      prev = fsync_o;
      step();
    end
    len = 0;
    while (pclk_o) begin
      len++;
      step();
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h;
    // R1: reset state
    steps(4);
    check("R1", {28'd0, pclk_o, sclk_o, fsync_o, bit_slot_o}, 0);
    rst = 1'b0;
    step();
    check("R1", {28'd0, pclk_o, sclk_o, fsync_o, bit_slot_o}, 15);
    measure_high(h);
    check("R1", h, 8);

    // R7: inputs change, no strobe
    set_cfg(1, 0, 0, 1, 1);
    measure_high(h); check("R7", h, 8);
    measure_high(h); check("R7", h, 8);

    // R2: slowest bit clock, fastest SPI clock
    set_cfg(0, 0, 5, 0, 0);
    strobe();
    measure_high(h); check("R2", h, 64);
    // R2: fastest with two clocks per bit, slowest SPI
    set_cfg(0, 5, 0, 1, 0);
    strobe();
    measure_high(h); check("R2", h, 2);
    // R2: code 7 clamps to code 5, R3 SPI code 6
    set_cfg(0, 7, 6, 0, 0);
    strobe();
    measure_high(h); check("R2", h, 2);
    steps(300);

    // R4: GCI one clock per bit, PCM code ignored
    set_cfg(1, 0, 2, 0, 0);
    strobe();
    measure_high(h); check("R4", h, 8);
    // R4: GCI two clocks per bit
    set_cfg(1, 0, 4, 1, 1);
    strobe();
    measure_high(h); check("R4", h, 4);

    // R8: later input changes ignored
    set_cfg(0, 2, 1, 0, 0);
    strobe();
    set_cfg(0, 4, 1, 0, 0);
    measure_high(h); check("R8", h, 16);
    // R8: last of two strobes wins
    set_cfg(0, 1, 3, 1, 0);
    strobe();
    steps(10);
    set_cfg(0, 4, 3, 0, 0);
    strobe();
    measure_high(h); check("R8", h, 4);

    // R10: strobe in the last frame cycle
    while (m_cnt != 4095) step();
    set_cfg(0, 1, 2, 0, 0);
    strobe();
    measure_high(h); check("R10", h, 32);
    steps(5000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule